// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write single bytes in an external asynchronous static RAM of 128K locations by 8 bits. The host raises a one-cycle request carrying a write flag, a 17-bit address and, for writes, a data byte. The controller latches these, runs the memory pins through setup, access, hold and (after reads) bus turnaround phases, and finishes with a one-cycle done pulse. For reads, the captured byte appears on the read-data output at that pulse.

The memory side has a low-true select, a high-true select, a low-true write strobe, a low-true output enable and the address. The data bus is split: an output byte, its tri-state enable and an input byte. Each phase length in clock cycles is computed from a clock-period parameter and the memory's nanosecond limits. The rounding is always upward, and every phase lasts at least one cycle.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever `busy` is low, the memory is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1 and `mem_doe`=0; `done` and `busy` reset to 0.
- R2: During a write, `mem_we_n` stays low for at least 55 ns of clock cycles while `mem_oe_n` is high. Address and output data stay constant for the whole low pulse. The address has been valid for at least 70 ns when `mem_we_n` rises, and the data for at least 40 ns.
- R3: A write keeps the memory selected for at least 85 ns in total.
- R4: A read holds `mem_we_n` high, pulls `mem_oe_n` low, keeps `mem_doe` low, and presents the addressed byte on `rdata` at the done pulse.
- R5: Read data is captured no earlier than 85 ns after address and select became valid, and no earlier than 45 ns after `mem_oe_n` fell.
- R6: `mem_doe` is never high while `mem_oe_n` is low. After `mem_oe_n` rises, at least 30 ns of cycles pass before `mem_doe` is raised again.
- R7: `busy` is high from the cycle after a request is accepted until `done`. `done` is a single-cycle pulse, and `busy` is low in that cycle.
- R8: A request raised while `busy` is high is ignored: it writes nothing and produces no done pulse.
- R9: Address, write flag and write data are latched when the request is accepted; host input changes during the access have no effect.
- R10: The two chip selects always agree: both active or both inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Captured read byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Low-true chip select |
| mem_cs | output | 1 | High-true chip select |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_dout | output | 8 | Data toward memory |
| mem_doe | output | 1 | Tri-state enable for `mem_dout` |
| mem_din | input | 8 | Data from memory |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is already running. The bench forks a second driver that raises a write request partway through another operation. It then reads back the target location, expecting its earlier value, and compares the number of done pulses with the number of accepted operations. The bench's memory model returns a garbage byte unless the access-time and enable-time limits have been met, so a read captured too early shows up as a data mismatch. A read followed directly by a write exercises the turnaround gap.

// File: rtl/asram_pkg.sv
package asram_pkg;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD,
        PH_TURN
    } phase_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_t;

    // cycles covering ns at clk_ns per cycle, never fewer than one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len_m1,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len_m1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int SETUP_C = 1,
    parameter int RD_ACT  = 21,
    parameter int RD_HOLD = 1,
    parameter int WR_ACT  = 17,
    parameter int WR_HOLD = 4,
    parameter int TURN_C  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_wr,
    input  logic             last,
    output phase_t           phase,
    output logic             load,
    output logic [CNT_W-1:0] len_m1,
    output logic             done
);
    localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_C - 1);
    localparam logic [CNT_W-1:0] L_RACT  = CNT_W'(RD_ACT - 1);
    localparam logic [CNT_W-1:0] L_RHOLD = CNT_W'(RD_HOLD - 1);
    localparam logic [CNT_W-1:0] L_WACT  = CNT_W'(WR_ACT - 1);
    localparam logic [CNT_W-1:0] L_WHOLD = CNT_W'(WR_HOLD - 1);
    localparam logic [CNT_W-1:0] L_TURN  = CNT_W'(TURN_C - 1);

    phase_t nxt;
    logic   fin;

    always_comb begin
        nxt    = phase;
        load   = 1'b0;
        len_m1 = '0;
        fin    = 1'b0;
        unique case (phase)
            PH_IDLE: if (start) begin
                nxt = PH_SETUP; load = 1'b1; len_m1 = L_SETUP;
            end
            PH_SETUP: if (last) begin
                nxt = PH_ACTIVE; load = 1'b1; len_m1 = is_wr ? L_WACT : L_RACT;
            end
            PH_ACTIVE: if (last) begin
                nxt = PH_HOLD; load = 1'b1; len_m1 = is_wr ? L_WHOLD : L_RHOLD;
            end
            PH_HOLD: if (last) begin
                if (is_wr) begin
                    nxt = PH_IDLE; fin = 1'b1;
                end else begin
                    nxt = PH_TURN; load = 1'b1; len_m1 = L_TURN;
                end
            end
            PH_TURN: if (last) begin
                nxt = PH_IDLE; fin = 1'b1;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= nxt;
            done  <= fin;
        end
    end

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: completion only coincides with the idle phase
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_NS    = 4,
    parameter int T_RC_NS   = 85,
    parameter int T_AA_NS   = 85,
    parameter int T_OE_NS   = 45,
    parameter int T_WP_NS   = 55,
    parameter int T_AW_NS   = 70,
    parameter int T_DW_NS   = 40,
    parameter int T_WC_NS   = 85,
    parameter int T_HZ_NS   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int SETUP_C = 1;
    localparam int RD_ACT  = imax(ns_to_cyc(T_AA_NS, CLK_NS) - SETUP_C,
                                  ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int RD_HOLD = imax(1, ns_to_cyc(T_RC_NS, CLK_NS) - SETUP_C - RD_ACT);
    localparam int WR_ACT  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                       ns_to_cyc(T_AW_NS, CLK_NS) - SETUP_C),
                                  ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int WR_HOLD = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_C - WR_ACT);
    localparam int TURN_C  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int MAX_C   = imax(imax(imax(RD_ACT, WR_ACT), imax(RD_HOLD, WR_HOLD)),
                                  imax(TURN_C, SETUP_C));
    localparam int CNT_W   = $clog2(MAX_C + 1);
    localparam int WP_MIN  = ns_to_cyc(T_WP_NS, CLK_NS);

    phase_t           phase;
    op_t              op_q;
    logic             start, last, load, sel;
    logic [CNT_W-1:0] len_m1;

    assign start = req && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst)
            op_q <= '0;
        else if (start)
            op_q <= '{wr: wr, addr: addr, data: wdata};
    end

    asram_seq #(
        .CNT_W(CNT_W), .SETUP_C(SETUP_C), .RD_ACT(RD_ACT), .RD_HOLD(RD_HOLD),
        .WR_ACT(WR_ACT), .WR_HOLD(WR_HOLD), .TURN_C(TURN_C)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .is_wr(op_q.wr), .last(last),
        .phase(phase), .load(load), .len_m1(len_m1), .done(done)
    );

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .len_m1(len_m1), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (phase == PH_ACTIVE && last && !op_q.wr)
            rdata <= mem_din;
    end

    assign sel      = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
    assign busy     = (phase != PH_IDLE);
    assign mem_cs_n = !sel;
    assign mem_cs   = sel;
    assign mem_we_n = !(sel && op_q.wr && phase == PH_ACTIVE);
    assign mem_oe_n = !(sel && !op_q.wr && phase == PH_ACTIVE);
    assign mem_doe  = sel && op_q.wr;
    assign mem_addr = op_q.addr;
    assign mem_dout = op_q.data;

    // checker state: length of the current write strobe
    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk) begin
        if (rst || mem_we_n)
            we_run_q <= '0;
        else
            we_run_q <= we_run_q + 1'b1;
    end

    // R1: idle means deselected and quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_doe));
    // R2: write strobe long enough
    p_we_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run_q >= (CNT_W+1)'(WP_MIN)));
    // R2: strobe and output enable never both low
    p_we_oe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);
    // R6: no driving into an enabled memory output
    p_no_drive_read_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_doe);
    // R8: latched operation frozen while busy
    p_req_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(op_q));
    // R7: busy falls together with done
    p_busy_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy, done;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_doe;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = 8'hEE;

    always #2 clk = ~clk;

    asram_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din)
    );

    int n_chk = 0, n_fail = 0;
    int n_ops = 0, n_done = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // memory model and pin-timing monitor
    logic [7:0]  mem   [int];
    logic [7:0]  shadow[int];
    int          acc_cnt = 0, oe_cnt = 0, oe_gap = 100;
    int          we_run = 0, we_acc = 0, sel_run = 0;
    bit          seen_wr = 0, we_bad = 0, doe_prev = 0;
    logic [16:0] acc_addr = '0, we_addr = '0;
    logic [7:0]  we_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit sel = !mem_cs_n && mem_cs;
            if (mem_cs_n == mem_cs)
                chk(0, "R10", "select pair", {mem_cs_n, mem_cs}, 2'b10);
            if (sel) begin
                sel_run++;
                if (!mem_we_n) seen_wr = 1;
            end else if (sel_run > 0) begin
                if (seen_wr) chk(sel_run * CLK_NS >= 85, "R3", "write select ns",
                                 sel_run * CLK_NS, 85);
                sel_run = 0; seen_wr = 0;
            end
            if (!sel) acc_cnt = 0;
            else if (mem_addr != acc_addr) acc_cnt = 1;
            else acc_cnt++;
            acc_addr = mem_addr;
            if (sel && !mem_oe_n) oe_cnt++; else oe_cnt = 0;
            if (sel && !mem_we_n) begin
                if (we_run == 0) begin we_addr = mem_addr; we_data = mem_dout; end
                else if (mem_addr != we_addr || mem_dout != we_data) we_bad = 1;
                we_run++;
                we_acc = acc_cnt;
            end else if (we_run > 0) begin
                chk(we_run * CLK_NS >= 55, "R2", "strobe ns", we_run * CLK_NS, 55);
                chk(we_acc * CLK_NS >= 70, "R2", "addr to end ns", we_acc * CLK_NS, 70);
                chk(!we_bad && we_run * CLK_NS >= 40, "R2", "data stable", we_bad, 0);
                mem[we_addr] = we_data;
                we_run = 0; we_bad = 0;
            end
            if (!mem_oe_n) oe_gap = 0; else if (oe_gap < 1000) oe_gap++;
            if (mem_doe && !doe_prev)
                chk(mem_oe_n && oe_gap * CLK_NS >= 30, "R6", "turnaround cycles", oe_gap, 8);
            doe_prev = mem_doe;
            if (sel && mem_we_n && !mem_oe_n && acc_cnt * CLK_NS >= 85 &&
                oe_cnt * CLK_NS >= 45 && mem.exists(mem_addr))
                mem_din = mem[mem_addr];
            else
                mem_din = 8'hEE;
        end
    end

    // scoreboard
    typedef struct {bit wr; logic [16:0] a; logic [7:0] exp;} item_t;
    item_t q[$];
    bit done_prev = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                n_done++;
                if (done_prev) chk(0, "R7", "done width", 2, 1);
                chk(!busy, "R7", "busy at done", busy, 0);
                if (q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
                else begin
                    automatic item_t it = q.pop_front();
                    if (!it.wr) chk(rdata == it.exp, "R4 R5", "read byte", rdata, it.exp);
                end
            end
            done_prev = done;
        end
    end

    task automatic do_op(input bit w, input logic [16:0] a, input logic [7:0] d);
        automatic item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1; wr = w; addr = a; wdata = d;
        it.wr = w; it.a = a;
        it.exp = shadow.exists(a) ? shadow[a] : 8'hEE;
        if (w) shadow[a] = d;
        q.push_back(it);
        n_ops++;
        @(negedge clk);
        req = 0; wr = ~w; addr = ~a; wdata = ~d;   // R9: inputs wander after acceptance
        chk(busy, "R7", "busy after accept", busy, 1);
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        chk(mem_cs_n && !mem_cs, "R1", "selects after reset", {mem_cs_n, mem_cs}, 2'b10);
        chk(mem_we_n && mem_oe_n && !mem_doe, "R1", "strobes after reset",
            {mem_we_n, mem_oe_n, mem_doe}, 3'b110);

        do_op(1, 17'h00000, 8'hA5);
        do_op(1, 17'h1FFFF, 8'h3C);
        do_op(1, 17'h12345, 8'h00);
        do_op(1, 17'h0AAAA, 8'hFF);
        do_op(0, 17'h00000, 8'h00);
        do_op(0, 17'h1FFFF, 8'h00);
        do_op(0, 17'h12345, 8'h00);
        do_op(1, 17'h0AAAA, 8'h5A);   // read-to-write turnaround (R6)
        do_op(0, 17'h0AAAA, 8'h00);
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_doe, "R1", "idle pins",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_doe}, 4'b1110);

        // R8: request while busy must vanish
        do_op(1, 17'h00200, 8'h22);
        fork
            do_op(1, 17'h00100, 8'h11);
            begin
                repeat (5) @(negedge clk);
                req = 1; wr = 1; addr = 17'h00200; wdata = 8'h99;
                @(negedge clk);
                req = 0;
            end
        join
        do_op(0, 17'h00200, 8'h00);
        do_op(0, 17'h00100, 8'h00);
        repeat (3) @(negedge clk);
        chk(n_done == n_ops, "R8", "done count", n_done, n_ops);
        chk(q.size() == 0, "R7", "pending items", q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * CLK_NS);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", n_done, n_ops);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule